// File: doc/BRIEF.md
# Segment-Indexed Vector Operand Broadcaster

This block sits in front of a lane-wise floating-point multiplier array. It takes one 32-bit instruction word of the indexed-element vector multiply form, together with two source vectors of a configurable length (a multiple of 128 bits). It decodes the element width, the three register numbers and the element index. It also checks the fixed opcode bits and flags any word that does not match.

For every lane it supplies two things. The first is the lane's own element of the first source. The second is an element of the second source, picked by the index. This element is re-selected inside each 128-bit segment, so every segment reuses its own copy of the chosen element and not the one in segment 0. All outputs are registered and qualified by a valid that trails the input valid by one cycle. The arithmetic, its rounding and the register file are left to the surrounding datapath.

Top module: `seg_bcast`

## Requirements
- R1: Bits 23:22 set the element width. The value 0x selects 16 bits and gives out_esize 0. The value 10 selects 32 bits and gives out_esize 1. The value 11 selects 64 bits and gives out_esize 2. The value 3 never appears on out_esize.
- R2: For 16-bit elements, out_idx is {bit 22, bits 20:19} and out_rm is bits 18:16, zero-extended.
- R3: For 32-bit elements, out_idx is bits 20:19, zero-extended, and out_rm is bits 18:16, zero-extended.
- R4: For 64-bit elements, out_idx is bit 20, zero-extended, and out_rm is bits 19:16, zero-extended.
- R5: out_rd is bits 4:0 and out_rn is bits 9:5.
- R6: A word is legal only if bits 31:24 equal 0x64, bit 21 is 1 and bits 15:10 equal 6'b001000. Any other word sets out_illegal and forces out_op_a and out_op_b to zero. The decoded fields are still reported.
- R7: For a legal word, out_op_a equals src_a. Every lane is active, and lane 0 sits in the least significant bits.
- R8: For a legal word with element width W and P = 128/W, lane e of out_op_b (bits e*W upward) holds element (e - e mod P) + index of src_b.
- R9: The lanes of the second and later segments take the indexed element from their own segment of src_b.
- R10: out_valid equals in_valid delayed by one cycle. Every other output changes only in the cycle after an accepted in_valid and holds its value otherwise.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and sources are present |
| in_word | input | 32 | Instruction word |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector (indexed) |
| out_valid | output | 1 | Outputs are valid for the last accepted word |
| out_illegal | output | 1 | Fixed opcode bits did not match |
| out_esize | output | 2 | Element width code (0:16, 1:32, 2:64) |
| out_rd | output | 5 | Destination register number |
| out_rn | output | 5 | First source register number |
| out_rm | output | 5 | Second source register number |
| out_idx | output | 3 | Decoded element index |
| out_op_a | output | VLEN | Per-lane first operands |
| out_op_b | output | VLEN | Per-lane indexed second operands |

## Verification
The assertions assume that in_valid and the data inputs are settled at the rising edge. They also assume that src_a is held only for the cycle it is accepted. Their properties use $past of the inputs for that one cycle, so they need no stability beyond it. The stimulus drives every input on the falling edge and puts fresh random vectors on both sources with each word. It walks every index of all three widths at a 256-bit length and mixes in words with corrupted fixed bits. It also leaves idle cycles in which the inputs change while in_valid is low, and these show that the outputs hold.

// File: rtl/seg_bcast_pkg.sv
package seg_bcast_pkg;

  typedef enum logic [1:0] {
    ESZ_H = 2'd0,
    ESZ_S = 2'd1,
    ESZ_D = 2'd2
  } esz_e;

  typedef struct packed {
    esz_e       esz;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
    logic [2:0] idx;
    logic       illegal;
  } dec_t;

  localparam logic [7:0] TOP_OPC = 8'b0110_0100;
  localparam logic [5:0] MID_OPC = 6'b00_1000;

  function automatic esz_e width_code(input logic [1:0] szf);
    if (!szf[1])     return ESZ_H;
    else if (!szf[0]) return ESZ_S;
    else             return ESZ_D;
  endfunction

  function automatic logic opc_ok(input logic [31:0] w);
    return (w[31:24] == TOP_OPC) && w[21] && (w[15:10] == MID_OPC);
  endfunction

  function automatic logic [2:0] index_of(input esz_e e, input logic [31:0] w);
    case (e)
      ESZ_H:   return {w[22], w[20:19]};
      ESZ_S:   return {1'b0, w[20:19]};
      default: return {2'b00, w[20]};
    endcase
  endfunction

  function automatic logic [4:0] rm_of(input esz_e e, input logic [31:0] w);
    if (e == ESZ_D) return {1'b0, w[19:16]};
    else            return {2'b00, w[18:16]};
  endfunction

endpackage

// File: rtl/seg_bcast_decode.sv
module seg_bcast_decode
  import seg_bcast_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);
  esz_e esz;

  always_comb begin
    esz         = width_code(word[23:22]);
    dec.esz     = esz;
    dec.rd      = word[4:0];
    dec.rn      = word[9:5];
    dec.rm      = rm_of(esz, word);
    dec.idx     = index_of(esz, word);
    dec.illegal = !opc_ok(word);
  end
endmodule

// File: rtl/seg_bcast_pick.sv
module seg_bcast_pick #(
  parameter int VLEN = 256,
  parameter int EW   = 32,
  parameter int IW   = 2
) (
  input  logic [VLEN-1:0] src,
  input  logic [IW-1:0]   idx,
  output logic [VLEN-1:0] dst
);
  localparam int SEG_W  = 128;
  localparam int NSEG   = VLEN / SEG_W;
  localparam int PER    = SEG_W / EW;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg;
    logic [EW-1:0]    chosen;
    assign seg    = src[s*SEG_W +: SEG_W];
    assign chosen = seg[idx*EW +: EW];
    for (genvar l = 0; l < PER; l++) begin : g_lane
      assign dst[s*SEG_W + l*EW +: EW] = chosen;
    end
  end
endmodule

// File: rtl/seg_bcast.sv
module seg_bcast
  import seg_bcast_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_word,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [1:0]      out_esize,
  output logic [4:0]      out_rd,
  output logic [4:0]      out_rn,
  output logic [4:0]      out_rm,
  output logic [2:0]      out_idx,
  output logic [VLEN-1:0] out_op_a,
  output logic [VLEN-1:0] out_op_b
);
  localparam int NSZ = 3;

  dec_t            dec;
  logic            dec_illegal;
  logic [VLEN-1:0] pick [NSZ];
  logic [VLEN-1:0] sel_b;
  logic [VLEN-1:0] sel_a;

  seg_bcast_decode u_dec (
    .word (in_word),
    .dec  (dec)
  );

  assign dec_illegal = dec.illegal;

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int EWG = 16 << g;
    localparam int IWG = 3 - g;
    seg_bcast_pick #(.VLEN(VLEN), .EW(EWG), .IW(IWG)) u_pick (
      .src (src_b),
      .idx (dec.idx[IWG-1:0]),
      .dst (pick[g])
    );
  end

  always_comb begin
    case (dec.esz)
      ESZ_H:   sel_b = pick[0];
      ESZ_S:   sel_b = pick[1];
      default: sel_b = pick[2];
    endcase
    if (dec_illegal) sel_b = '0;
    sel_a = dec_illegal ? '0 : src_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_esize   <= '0;
      out_rd      <= '0;
      out_rn      <= '0;
      out_rm      <= '0;
      out_idx     <= '0;
      out_op_a    <= '0;
      out_op_b    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= dec_illegal;
        out_esize   <= dec.esz;
        out_rd      <= dec.rd;
        out_rn      <= dec.rn;
        out_rm      <= dec.rm;
        out_idx     <= dec.idx;
        out_op_a    <= sel_a;
        out_op_b    <= sel_b;
      end
    end
  end
endmodule

// File: rtl/seg_bcast_chk.sv
module seg_bcast_chk #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [VLEN-1:0] src_a,
  input logic            dec_illegal,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [1:0]      out_esize,
  input logic [4:0]      out_rm,
  input logic [2:0]      out_idx,
  input logic [VLEN-1:0] out_op_a,
  input logic [VLEN-1:0] out_op_b
);
  // R1
  esize_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_esize != 2'd3);

  // R2
  narrow_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_esize != 2'd2) |-> out_rm[4:3] == 2'b00);

  // R3
  idx_s_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_esize == 2'd1) |-> out_idx <= 3'd3);

  // R4
  idx_d_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_esize == 2'd2) |-> out_idx <= 3'd1);

  // R6
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_op_a == '0 && out_op_b == '0));

  // R6
  illegal_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_illegal == $past(dec_illegal));

  // R7
  op_a_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_illegal) |=> out_op_a == $past(src_a));

  // R10
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_op_b) && $stable(out_idx) && $stable(out_esize)));
endmodule

bind seg_bcast seg_bcast_chk #(.VLEN(VLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .src_a       (src_a),
  .dec_illegal (dec_illegal),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_esize   (out_esize),
  .out_rm      (out_rm),
  .out_idx     (out_idx),
  .out_op_a    (out_op_a),
  .out_op_b    (out_op_b)
);

// File: tb/seg_bcast_bench.sv
module seg_bcast_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VLEN       = 256;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     in_word = '0;
  logic [VLEN-1:0] src_a = '0;
  logic [VLEN-1:0] src_b = '0;
  logic            out_valid, out_illegal;
  logic [1:0]      out_esize;
  logic [4:0]      out_rd, out_rn, out_rm;
  logic [2:0]      out_idx;
  logic [VLEN-1:0] out_op_a, out_op_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  seg_bcast #(.VLEN(VLEN)) u_seg_bcast (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_esize(out_esize), .out_rd(out_rd),
    .out_rn(out_rn), .out_rm(out_rm), .out_idx(out_idx),
    .out_op_a(out_op_a), .out_op_b(out_op_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic            m_valid = 1'b0, m_illegal = 1'b0;
  logic [1:0]      m_esize = '0;
  logic [4:0]      m_rd = '0, m_rn = '0, m_rm = '0;
  logic [2:0]      m_idx = '0;
  logic [VLEN-1:0] m_a = '0, m_b = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_illegal = 0; m_esize = 0; m_rd = 0; m_rn = 0;
      m_rm = 0; m_idx = 0; m_a = 0; m_b = 0;
    end else begin
      m_valid = in_valid;
      if (in_valid) begin
        int w;
        int per;
        logic legal;
        legal = (in_word[31:24] == 8'h64) && in_word[21] && (in_word[15:10] == 6'h08);
        if (!in_word[23]) begin
          w = 16; m_esize = 0; m_idx = {in_word[22], in_word[20:19]};
          m_rm = {2'b00, in_word[18:16]};
        end else if (!in_word[22]) begin
          w = 32; m_esize = 1; m_idx = {1'b0, in_word[20:19]};
          m_rm = {2'b00, in_word[18:16]};
        end else begin
          w = 64; m_esize = 2; m_idx = {2'b00, in_word[20]};
          m_rm = {1'b0, in_word[19:16]};
        end
        m_rd = in_word[4:0];
        m_rn = in_word[9:5];
        m_illegal = !legal;
        per = 128 / w;
        m_a = legal ? src_a : '0;
        m_b = '0;
        if (legal)
          for (int e = 0; e < VLEN / w; e++) begin
            int s;
            s = (e - (e % per)) + int'(m_idx);
            for (int k = 0; k < w; k++) m_b[e*w + k] = src_b[s*w + k];
          end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string rq;
      rq = (m_esize == 0) ? "R2" : (m_esize == 1) ? "R3" : "R4";
      check(out_valid == m_valid, "R10", "valid", out_valid, m_valid);
      check(out_esize == m_esize, "R1", "esize", out_esize, m_esize);
      check(out_idx == m_idx, rq, "index", out_idx, m_idx);
      check(out_rm == m_rm, rq, "rm", out_rm, m_rm);
      check(out_rd == m_rd && out_rn == m_rn, "R5", "rd/rn",
            {out_rd, out_rn}, {m_rd, m_rn});
      check(out_illegal == m_illegal, "R6", "illegal", out_illegal, m_illegal);
      check(out_op_a == m_a, "R7", "op_a", out_op_a, m_a);
      check(out_op_b[127:0] == m_b[127:0], "R8", "op_b seg0",
            out_op_b[127:0], m_b[127:0]);
      check(out_op_b[VLEN-1:128] == m_b[VLEN-1:128], "R9", "op_b upper",
            out_op_b[VLEN-1:128], m_b[VLEN-1:128]);
    end
  end

  function automatic logic [31:0] enc(input int sz, input int idx, input int rm,
                                      input int rn, input int rd);
    logic [31:0] w;
    w = 32'h0;
    w[31:24] = 8'h64;
    w[21] = 1'b1;
    w[15:10] = 6'h08;
    w[9:5] = rn[4:0];
    w[4:0] = rd[4:0];
    case (sz)
      16: begin w[23] = 0; w[22] = idx[2]; w[20:19] = idx[1:0]; w[18:16] = rm[2:0]; end
      32: begin w[23:22] = 2'b10; w[20:19] = idx[1:0]; w[18:16] = rm[2:0]; end
      default: begin w[23:22] = 2'b11; w[20] = idx[0]; w[19:16] = rm[3:0]; end
    endcase
    return w;
  endfunction

  task automatic rand_src();
    for (int i = 0; i < VLEN/32; i++) begin
      src_a[i*32 +: 32] = $urandom;
      src_b[i*32 +: 32] = $urandom;
    end
  endtask

  task automatic send(input logic [31:0] w, input bit gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    rand_src();
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = $urandom;
      rand_src();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rand_src();
    in_word = $urandom;
    repeat (2) @(negedge clk);
    // R11: outputs zero during reset
    check(out_valid == 0 && out_illegal == 0 && out_esize == 0, "R11", "ctl",
          {out_valid, out_illegal, out_esize}, '0);
    check(out_op_a == '0 && out_op_b == '0 && out_idx == 0 && out_rm == 0, "R11",
          "data", out_op_a | out_op_b, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int rep = 0; rep < 3; rep++) begin
      for (int i = 0; i < 8; i++) send(enc(16, i, $urandom, $urandom, $urandom), rep[0]);
      for (int i = 0; i < 4; i++) send(enc(32, i, $urandom, $urandom, $urandom), rep[0]);
      for (int i = 0; i < 2; i++) send(enc(64, i, $urandom, $urandom, $urandom), rep[0]);
    end
    // R6: corrupt each fixed region
    send(enc(32, 1, 3, 4, 5) ^ 32'h8000_0000, 1'b1);
    send(enc(16, 5, 2, 7, 9) ^ 32'h0020_0000, 1'b0);
    send(enc(64, 1, 9, 1, 2) ^ 32'h0000_1000, 1'b1);
    send(enc(32, 3, 1, 2, 3) ^ 32'h0100_0000, 1'b0);
    send(enc(16, 0, 0, 31, 31), 1'b1);
    for (int i = 0; i < 40; i++) send($urandom, i[0]);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule